// File: doc/BRIEF.md
# Reset-Time Configuration Strap Capture with Address Pin Sharing

Three low-order address pins of an external memory bus do a second job while the chip is held in reset: they act as configuration inputs. Each pin gets a weak pull-down during reset, and its output driver stays off so an external resistor sets its level. When reset is released, the block records the three levels, turns off the pull-downs and gives the pins back to the memory address path. Bit 2 selects between crystal operation and an externally driven clock. Bits 1:0 give the frequency of the external clock, and codes that are not defined raise a flag.

After reset, the recorded level of each pin also sets how that pin behaves when the chip sleeps. A pin recorded as 0 always drives its address bit. A pin recorded as 1 floats whenever the CPU idle bit is set, interrupt 2 is inactive and the clock-control sleep bit is set, all at the same time. In every other condition it drives its address bit. The decision to drive or float is taken from a register, so the output enables change only on clock edges.

Top module: `bsm_strap_mux`

## Requirements
- R1: While the internal reset is active, `pad_oe` is 000, `pad_pd_en` is 111 and `pad_out` is 000.
- R2: The recorded straps (`clk_ext_mode`, `freq_sel`, `freq_reserved`) come from `pad_in` as sampled on the clock edge that ends the internal reset. After that they do not change until the next reset, whatever `pad_in` does.
- R3: From the edge that ends the internal reset, `pad_pd_en` is 000.
- R4: `clk_ext_mode` equals the recorded level of pin 2: 0 means crystal at 24 MHz, 1 means an external clock.
- R5: The recorded pins 1:0 decode as follows:
  - code 00 gives `freq_sel`=0 (24 MHz) and `freq_reserved`=0;
  - code 11 gives `freq_sel`=1 (48 MHz) and `freq_reserved`=0;
  - codes 01 and 10 give `freq_reserved`=1 and `freq_sel`=0.
- R6: After reset, a pin whose recorded level is 0 has `pad_oe`=1 on every edge, starting with the second edge after reset ends.
- R7: After reset, a pin whose recorded level is 1 has `pad_oe`=0 one cycle after an edge at which `cpu_idle`=1, `irq2`=0 and `clk_sleep`=1. Otherwise its `pad_oe` is 1.
- R8: After reset, `pad_out` equals `addr_in` delayed by one clock.
- R9: A low level on `rst_n` puts the internal reset into effect at once, with no clock needed. A rising edge of `rst_n` takes effect only after two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous to clk |
| addr_in | input | 3 | Internal memory address bits 2:0 |
| pad_in | input | 3 | Sampled level of the three pads |
| cpu_idle | input | 1 | CPU idle bit |
| irq2 | input | 1 | Interrupt 2, active high |
| clk_sleep | input | 1 | Sleep bit of the clock-control register |
| pad_out | output | 3 | Pad output value |
| pad_oe | output | 3 | Pad output enable, 1 = drive |
| pad_pd_en | output | 3 | Weak pull-down enable |
| clk_ext_mode | output | 1 | Recorded clock-mode strap |
| freq_sel | output | 1 | 0 = 24 MHz, 1 = 48 MHz |
| freq_reserved | output | 1 | Recorded frequency code is undefined |

## Verification
The bench covers all eight strap patterns and then changes `pad_in` after release. A design that keeps following the pads, or samples them one edge late, shows strap outputs that drift away from the recorded value.

The bench also drives the three sleep inputs in every combination. A pin that floats when only some of the sleep conditions hold fails the check, and so does a pin recorded as 0 that ever floats. The bench also checks the one-cycle delay of the enable against the sleep inputs.

The two reserved codes are checked for the flag and for the 24 MHz fallback. A reset that waits for a clock, or a release counted on the wrong number of edges, shows up in the checks taken right after `rst_n` changes.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  typedef enum logic {
    FREQ_24 = 1'b0,
    FREQ_48 = 1'b1
  } freq_e;

  typedef struct packed {
    logic  ext_clk;
    freq_e freq;
    logic  reserved;
  } strap_cfg_t;

  function automatic strap_cfg_t decode_straps(input logic [2:0] lvl);
    strap_cfg_t c;
    c.ext_clk  = lvl[2];
    c.reserved = lvl[1] ^ lvl[0];
    c.freq     = (lvl[1] & lvl[0]) ? FREQ_48 : FREQ_24;
    return c;
  endfunction

endpackage

// File: rtl/bsm_reset_sync.sv
module bsm_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_int = ~chain_q[STAGES-1];

  // R9: once rst_n has been high for a while the chain must be fully released
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !rst_int |=> !rst_int);

endmodule

// File: rtl/bsm_strap_capture.sv
module bsm_strap_capture
  import bsm_pkg::*;
#(
  parameter int NUM_PINS = 3
) (
  input  logic                clk,
  input  logic                rst_int,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] strap_lvl,
  output strap_cfg_t          cfg
);

  logic [NUM_PINS-1:0] lvl_q;
  strap_cfg_t          cfg_q;

  always_ff @(posedge clk) begin
    if (rst_int) begin
      lvl_q <= pad_in;
      cfg_q <= decode_straps(pad_in[2:0]);
    end
  end

  assign strap_lvl = lvl_q;
  assign cfg       = cfg_q;

  // R2: recorded straps frozen outside reset
  p_strap_hold_r2: assert property (@(posedge clk) disable iff (rst_int)
    !rst_int |=> $stable(lvl_q) && $stable(cfg_q));

  // R5: an undefined code falls back to the slow frequency
  p_reserved_default_r5: assert property (@(posedge clk) disable iff (rst_int)
    cfg_q.reserved |-> cfg_q.freq == FREQ_24);

  // R4: the clock-mode output follows pin 2
  p_clk_mode_r4: assert property (@(posedge clk) disable iff (rst_int)
    cfg_q.ext_clk == lvl_q[2]);

endmodule

// File: rtl/bsm_pad_cell.sv
module bsm_pad_cell (
  input  logic clk,
  input  logic rst_int,
  input  logic strap,
  input  logic sleep_req,
  input  logic addr,
  output logic out,
  output logic oe,
  output logic pd_en
);

  logic out_q;
  logic oe_q;

  always_ff @(posedge clk or posedge rst_int) begin
    if (rst_int) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      out_q <= addr;
      oe_q  <= ~(strap & sleep_req);
    end
  end

  assign out   = out_q;
  assign oe    = oe_q;
  assign pd_en = rst_int;

  // R1: never drive against the strap resistor during reset
  p_oe_off_in_reset_r1: assert property (@(posedge clk)
    rst_int |-> !oe_q && !out_q);

  // R6: a pin recorded as 0 never floats after reset
  p_fixed_pin_r6: assert property (@(posedge clk) disable iff (rst_int)
    !strap && !$past(rst_int) |-> oe_q);

  // R7: a pin recorded as 1 floats in the cycle after a sleep request
  p_float_r7: assert property (@(posedge clk) disable iff (rst_int)
    strap && !$past(rst_int) |-> oe_q == !$past(sleep_req));

  // R8: address passes with one cycle latency
  p_addr_follow_r8: assert property (@(posedge clk) disable iff (rst_int)
    !$past(rst_int) |-> out_q == $past(addr));

endmodule

// File: rtl/bsm_strap_mux.sv
module bsm_strap_mux
  import bsm_pkg::*;
#(
  parameter int NUM_PINS    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] addr_in,
  input  logic [NUM_PINS-1:0] pad_in,
  input  logic                cpu_idle,
  input  logic                irq2,
  input  logic                clk_sleep,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_pd_en,
  output logic                clk_ext_mode,
  output logic                freq_sel,
  output logic                freq_reserved
);

  logic                rst_int;
  logic                sleep_req;
  logic [NUM_PINS-1:0] strap_lvl;
  strap_cfg_t          cfg;

  bsm_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_int(rst_int)
  );

  bsm_strap_capture #(.NUM_PINS(NUM_PINS)) u_cap (
    .clk      (clk),
    .rst_int  (rst_int),
    .pad_in   (pad_in),
    .strap_lvl(strap_lvl),
    .cfg      (cfg)
  );

  assign sleep_req = cpu_idle & ~irq2 & clk_sleep;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    bsm_pad_cell u_cell (
      .clk      (clk),
      .rst_int  (rst_int),
      .strap    (strap_lvl[i]),
      .sleep_req(sleep_req),
      .addr     (addr_in[i]),
      .out      (pad_out[i]),
      .oe       (pad_oe[i]),
      .pd_en    (pad_pd_en[i])
    );
  end

  assign clk_ext_mode  = cfg.ext_clk;
  assign freq_sel      = cfg.freq;
  assign freq_reserved = cfg.reserved;

  // R3: pull-downs released with reset
  p_pd_off_r3: assert property (@(posedge clk) disable iff (rst_int)
    pad_pd_en == '0);

endmodule

// File: tb/bsm_strap_mux_test.sv
module bsm_strap_mux_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr_in = '0, pad_in = '0;
  logic       cpu_idle = 0, irq2 = 0, clk_sleep = 0;
  logic [2:0] pad_out, pad_oe, pad_pd_en;
  logic       clk_ext_mode, freq_sel, freq_reserved;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bsm_strap_mux uut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .pad_in(pad_in),
    .cpu_idle(cpu_idle), .irq2(irq2), .clk_sleep(clk_sleep),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pd_en(pad_pd_en),
    .clk_ext_mode(clk_ext_mode), .freq_sel(freq_sel), .freq_reserved(freq_reserved)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_freq(input logic [2:0] s);
    return s[1] & s[0];
  endfunction
  function automatic logic exp_rsv(input logic [2:0] s);
    return s[1] != s[0];
  endfunction
  function automatic logic [2:0] exp_oe(input logic [2:0] s, input logic slp);
    return slp ? ~s : 3'b111;
  endfunction

  task automatic check_straps(input logic [2:0] s);
    chk("R4 clk_ext_mode", {7'd0, clk_ext_mode}, {7'd0, s[2]});
    chk("R5 freq_sel", {7'd0, freq_sel}, {7'd0, exp_freq(s)});
    chk("R5 freq_reserved", {7'd0, freq_reserved}, {7'd0, exp_rsv(s)});
  endtask

  task automatic run_phase(input logic [2:0] s, input int cycles);
    logic       prev_slp;
    logic [2:0] prev_addr;
    @(negedge clk);
    rst_n = 1'b0;
    pad_in = s;
    #1;
    chk("R9 async oe", {5'd0, pad_oe}, 8'd0);
    chk("R9 async pd", {5'd0, pad_pd_en}, 8'd7);
    repeat (3) @(negedge clk);
    chk("R1 oe", {5'd0, pad_oe}, 8'd0);
    chk("R1 pd", {5'd0, pad_pd_en}, 8'd7);
    chk("R1 out", {5'd0, pad_out}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 still in reset", {5'd0, pad_pd_en}, 8'd7);
    @(negedge clk);
    chk("R3 pd off", {5'd0, pad_pd_en}, 8'd0);
    chk("R1 oe at release", {5'd0, pad_oe}, 8'd0);
    check_straps(s);
    prev_slp = 0;
    prev_addr = '0;
    for (int c = 0; c < cycles; c++) begin
      cpu_idle  = ($urandom % 4) != 0;
      irq2      = ($urandom % 4) == 0;
      clk_sleep = ($urandom % 4) != 0;
      addr_in   = 3'($urandom);
      pad_in    = 3'($urandom);
      prev_slp  = cpu_idle & ~irq2 & clk_sleep;
      prev_addr = addr_in;
      @(negedge clk);
      chk("R6/R7 oe", {5'd0, pad_oe}, {5'd0, exp_oe(s, prev_slp)});
      chk("R8 out", {5'd0, pad_out}, {5'd0, prev_addr});
      if (c % 16 == 0) begin
        chk("R2 hold ext", {7'd0, clk_ext_mode}, {7'd0, s[2]});
        chk("R2 hold freq", {6'd0, freq_sel, freq_reserved},
            {6'd0, exp_freq(s), exp_rsv(s)});
      end
    end
  endtask

  task automatic sleep_combos(input logic [2:0] s);
    for (int k = 0; k < 8; k++) begin
      cpu_idle = k[0]; irq2 = k[1]; clk_sleep = k[2];
      @(negedge clk);
      chk("R7 combo", {5'd0, pad_oe},
          {5'd0, exp_oe(s, k[0] & ~k[1] & k[2])});
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    #1;
    chk("R1 oe at start", {5'd0, pad_oe}, 8'd0);
    for (int p = 0; p < 8; p++) begin
      run_phase(3'(p), 40);
      sleep_combos(3'(p));
    end
    for (int p = 0; p < 6; p++) run_phase(3'($urandom), 60);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule